// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block drives an active-low system reset from a set of digital "supply good" flags, each produced by an external threshold comparator. Reset is released only after every flag has stayed good for an uninterrupted timeout, counted in clock cycles. The timeout has two lengths, a long internal default and a short alternative, and a select input picks between them. All asynchronous inputs pass through a multi-stage synchronizer before the control logic sees them.

A hold request freezes the reset output, so supplies can be margined up and down without disturbing the system. When the hold is dropped, the reset level that was frozen and the flags at that moment decide what happens next. A released reset whose flags are all good stays released. A released reset with a bad flag asserts after a short fixed delay. An asserted reset whose flags are all good waits one complete fresh timeout. At power-up the block starts in the held state with reset asserted, so a hold request that is present from the start keeps the system in reset until it goes away.

Top module: `supply_reset_sequencer`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is 0. After `por_n` rises, the block behaves as if a hold had been active with reset asserted: the timeout counter starts from zero and `sys_rst_n` stays 0 until a full timeout completes.
- R2: Outside hold, with `sys_rst_n` at 0 and every bit of `supply_ok` at 1, `sys_rst_n` rises at the (SYNC_STAGES + timeout)-th rising clock edge after the last flag turned good, and not earlier.
- R3: `long_sel` = 1 selects a timeout of LONG_CYCLES cycles. `long_sel` = 0 selects SHORT_CYCLES cycles.
- R4: Outside hold, any `supply_ok` bit at 0 drives `sys_rst_n` to 0 at the (SYNC_STAGES + 1)-th edge and clears the timeout counter, so a one-cycle glitch costs a complete new timeout.
- R5: While `hold_req` is 1, `sys_rst_n` keeps its level and ignores `supply_ok`. A hold request and a flag dropping in the same cycle are resolved in favour of the hold.
- R6: Hold dropped while `sys_rst_n` is 1 and all flags are good: `sys_rst_n` stays 1, whatever the flags did during the hold.
- R7: Hold dropped while `sys_rst_n` is 1 and any flag is bad: `sys_rst_n` falls at the (SYNC_STAGES + 1 + RELEASE_DLY)-th edge after `hold_req` falls.
- R8: Hold dropped while `sys_rst_n` is 0: any partial count from before the hold is discarded. With all flags good, `sys_rst_n` rises at the (SYNC_STAGES + 1 + timeout)-th edge after `hold_req` falls. With a bad flag, it stays 0.
- R9: A hold request present at power-up keeps `sys_rst_n` at 0 for as long as it lasts, however long the flags have been good. The full timeout starts only at its release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | NUM_SUPPLIES | Per-supply good flags from comparators, asynchronous |
| hold_req | input | 1 | Hold (margining) request, active high, asynchronous |
| long_sel | input | 1 | 1 selects the long timeout, 0 the short one |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
Two functions can meet in one control cycle: entry into hold, and a flag dropping outside hold. The bench provokes this by changing `hold_req` and a `supply_ok` bit on the same clock edge while reset is released. Both then clear the synchronizer together. The pass criterion is that reset stays high through the whole hold, because the hold has priority. A second collision comes from dropping the hold while a flag is bad with reset released, and while a partial count is pending with reset asserted. These are judged by the exact edge on which reset falls or rises after the release.

// File: rtl/srs_pkg.sv
package srs_pkg;

   // Control modes of the sequencer
   typedef enum logic [1:0] {
      MODE_RUN  = 2'd0,   // normal supervision
      MODE_HOLD = 2'd1,   // output frozen by hold request
      MODE_DROP = 2'd2    // release delay before forced assertion
   } mode_e;

   // Counter width able to hold values 0..max_val
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srs_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("srs_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[s] <= RST_VAL;
               else         chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[s] <= RST_VAL;
               else         chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/srs_timer.sv
module srs_timer #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [WIDTH-1:0] limit,
   output logic [WIDTH-1:0] cnt,
   output logic             hit
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("srs_timer: WIDTH must be at least 1");
      end
   endgenerate

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   // hit marks the enabled cycle that completes limit counted cycles
   assign hit = en && !clr && (cnt == (limit - ONE));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (hit)    cnt <= '0;
      else if (en)     cnt <= cnt + ONE;
   end

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
   import srs_pkg::*;
(
   input  logic  clk,
   input  logic  arst_n,
   input  logic  all_ok,
   input  logic  hold,
   input  logic  to_hit,
   input  logic  dl_hit,
   output logic  to_clr,
   output logic  to_en,
   output logic  dl_clr,
   output logic  dl_en,
   output mode_e mode,
   output logic  rst_n
);

   mode_e mode_d;
   logic  rst_d;

   always_comb begin
      mode_d = mode;
      rst_d  = rst_n;
      to_clr = 1'b0;
      to_en  = 1'b0;
      dl_clr = 1'b0;
      dl_en  = 1'b0;
      unique case (mode)
         MODE_RUN: begin
            if (hold) begin
               // hold wins over any simultaneous flag change
               mode_d = MODE_HOLD;
               to_clr = 1'b1;
            end else if (!all_ok) begin
               rst_d  = 1'b0;
               to_clr = 1'b1;
            end else if (!rst_n) begin
               to_en = 1'b1;
               if (to_hit) rst_d = 1'b1;
            end
         end
         MODE_HOLD: begin
            if (!hold) begin
               if (rst_n && all_ok) begin
                  mode_d = MODE_RUN;
               end else if (rst_n) begin
                  mode_d = MODE_DROP;
                  dl_clr = 1'b1;
               end else begin
                  mode_d = MODE_RUN;
                  to_clr = 1'b1;
               end
            end
         end
         MODE_DROP: begin
            dl_en = 1'b1;
            if (dl_hit) begin
               rst_d  = 1'b0;
               mode_d = MODE_RUN;
               to_clr = 1'b1;
            end
         end
         default: begin
            mode_d = MODE_HOLD;
            rst_d  = 1'b0;
            to_clr = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         mode  <= MODE_HOLD;
         rst_n <= 1'b0;
      end else begin
         mode  <= mode_d;
         rst_n <= rst_d;
      end
   end

endmodule

// File: rtl/supply_reset_sequencer.sv
module supply_reset_sequencer
   import srs_pkg::*;
#(
   parameter int NUM_SUPPLIES = 3,
   parameter int SYNC_STAGES  = 2,
   parameter int SHORT_CYCLES = 40_000,
   parameter int LONG_CYCLES  = 20_000_000,
   parameter int RELEASE_DLY  = 2
) (
   input  logic                    clk,
   input  logic                    por_n,
   input  logic [NUM_SUPPLIES-1:0] supply_ok,
   input  logic                    hold_req,
   input  logic                    long_sel,
   output logic                    sys_rst_n
);

   localparam int CNT_W  = cnt_width(LONG_CYCLES);
   localparam int DLY_W  = cnt_width(RELEASE_DLY);
   localparam int SYNC_W = NUM_SUPPLIES + 2;
   // long select and hold come out of reset set, supply flags cleared
   localparam logic [SYNC_W-1:0] SYNC_RST = {2'b11, {NUM_SUPPLIES{1'b0}}};
   localparam logic [CNT_W-1:0]  LIM_LONG  = CNT_W'(LONG_CYCLES);
   localparam logic [CNT_W-1:0]  LIM_SHORT = CNT_W'(SHORT_CYCLES);
   localparam logic [DLY_W-1:0]  LIM_DLY   = DLY_W'(RELEASE_DLY);

   generate
      if (NUM_SUPPLIES < 1) begin : g_bad_num
         $error("supply_reset_sequencer: NUM_SUPPLIES must be at least 1");
      end
      if (SHORT_CYCLES < 1 || LONG_CYCLES < SHORT_CYCLES) begin : g_bad_to
         $error("supply_reset_sequencer: need 1 <= SHORT_CYCLES <= LONG_CYCLES");
      end
      if (RELEASE_DLY < 1) begin : g_bad_dly
         $error("supply_reset_sequencer: RELEASE_DLY must be at least 1");
      end
   endgenerate

   logic [SYNC_W-1:0]       sync_q;
   logic [NUM_SUPPLIES-1:0] ok_s;
   logic                    hold_s;
   logic                    sel_s;
   logic                    all_ok;

   srs_sync #(
      .WIDTH   (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk    (clk),
      .arst_n (por_n),
      .d      ({long_sel, hold_req, supply_ok}),
      .q      (sync_q)
   );

   assign ok_s   = sync_q[NUM_SUPPLIES-1:0];
   assign hold_s = sync_q[NUM_SUPPLIES];
   assign sel_s  = sync_q[NUM_SUPPLIES+1];
   assign all_ok = &ok_s;

   logic             to_clr, to_en, to_hit;
   logic             dl_clr, dl_en, dl_hit;
   logic [CNT_W-1:0] to_cnt;
   logic [DLY_W-1:0] dl_cnt;
   logic [CNT_W-1:0] to_limit;
   mode_e            mode;

   assign to_limit = sel_s ? LIM_LONG : LIM_SHORT;

   srs_timer #(.WIDTH(CNT_W)) u_timeout (
      .clk    (clk),
      .arst_n (por_n),
      .clr    (to_clr),
      .en     (to_en),
      .limit  (to_limit),
      .cnt    (to_cnt),
      .hit    (to_hit)
   );

   srs_timer #(.WIDTH(DLY_W)) u_reldly (
      .clk    (clk),
      .arst_n (por_n),
      .clr    (dl_clr),
      .en     (dl_en),
      .limit  (LIM_DLY),
      .cnt    (dl_cnt),
      .hit    (dl_hit)
   );

   srs_ctrl u_ctrl (
      .clk    (clk),
      .arst_n (por_n),
      .all_ok (all_ok),
      .hold   (hold_s),
      .to_hit (to_hit),
      .dl_hit (dl_hit),
      .to_clr (to_clr),
      .to_en  (to_en),
      .dl_clr (dl_clr),
      .dl_en  (dl_en),
      .mode   (mode),
      .rst_n  (sys_rst_n)
   );

endmodule

// File: rtl/srs_checker.sv
module srs_checker
   import srs_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int DLY_W       = 2,
   parameter int LONG_CYCLES = 16,
   parameter int RELEASE_DLY = 2
) (
   input logic             clk,
   input logic             por_n,
   input logic             sys_rst_n,
   input logic             all_ok,
   input logic             hold_s,
   input mode_e            mode,
   input logic [CNT_W-1:0] to_cnt,
   input logic [DLY_W-1:0] dl_cnt
);

   AST_POR_LOW: assert property (@(posedge clk) !por_n |-> !sys_rst_n); // R1

   AST_RISE_NEEDS_OK: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst_n) |-> $past(all_ok)); // R2

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
      to_cnt < CNT_W'(LONG_CYCLES)); // R3

   AST_DROP_ASSERTS: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MODE_RUN && !hold_s && !all_ok) |=> !sys_rst_n); // R4

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!por_n)
      (hold_s && mode != MODE_DROP) |=> $stable(sys_rst_n)); // R5

   AST_RELEASE_KEEP: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MODE_HOLD && !hold_s && sys_rst_n && all_ok) |=> sys_rst_n); // R6

   AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MODE_HOLD && !hold_s && sys_rst_n && !all_ok)
      |=> (mode == MODE_DROP && sys_rst_n)); // R7

   AST_DLY_BOUND: assert property (@(posedge clk) disable iff (!por_n)
      dl_cnt < DLY_W'(RELEASE_DLY)); // R7

   AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
      $fell(sys_rst_n) |-> ($past(!all_ok) || $past(mode) == MODE_DROP)); // R8

endmodule

bind supply_reset_sequencer srs_checker #(
   .CNT_W       (CNT_W),
   .DLY_W       (DLY_W),
   .LONG_CYCLES (LONG_CYCLES),
   .RELEASE_DLY (RELEASE_DLY)
) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .sys_rst_n (sys_rst_n),
   .all_ok    (all_ok),
   .hold_s    (hold_s),
   .mode      (mode),
   .to_cnt    (to_cnt),
   .dl_cnt    (dl_cnt)
);

// File: tb/supply_reset_sequencer_test.sv
module supply_reset_sequencer_test;

   localparam int CLK_PERIOD = 10;
   localparam int N     = 3;
   localparam int SYNC  = 2;
   localparam int SHORT = 5;
   localparam int LONG  = 12;
   localparam int DLY   = 2;

   logic         clk = 1'b0;
   logic         por_n = 1'b0;
   logic [N-1:0] supply_ok = '0;
   logic         hold_req = 1'b0;
   logic         long_sel = 1'b0;
   logic         sys_rst_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   supply_reset_sequencer #(
      .NUM_SUPPLIES (N),
      .SYNC_STAGES  (SYNC),
      .SHORT_CYCLES (SHORT),
      .LONG_CYCLES  (LONG),
      .RELEASE_DLY  (DLY)
   ) uut (
      .clk       (clk),
      .por_n     (por_n),
      .supply_ok (supply_ok),
      .hold_req  (hold_req),
      .long_sel  (long_sel),
      .sys_rst_n (sys_rst_n)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic exp);
      checks++;
      if (sys_rst_n !== exp) begin
         errors++;
         $display("FAIL %s: sys_rst_n=%b expected=%b at %0t", req, sys_rst_n, exp, $time);
      end
   endtask

   task automatic t_reset();
      step(3);
      check("R1 during por", 1'b0);
      por_n = 1'b1;
      step(3);
      check("R1 after por", 1'b0);
   endtask

   task automatic t_short_timeout();
      supply_ok = '1;
      step(SYNC + SHORT - 1);
      check("R2 before timeout", 1'b0);
      step(1);
      check("R2 at timeout", 1'b1);
   endtask

   task automatic t_drop_and_glitch();
      supply_ok = 3'b101;
      step(SYNC);
      check("R4 before drop seen", 1'b1);
      step(1);
      check("R4 drop asserts", 1'b0);
      supply_ok = '1;
      step(4);
      supply_ok = 3'b110;
      step(1);
      supply_ok = '1;
      step(SYNC + SHORT - 1);
      check("R4 glitch restarts count", 1'b0);
      step(1);
      check("R4 full timeout after glitch", 1'b1);
   endtask

   task automatic t_long_select();
      supply_ok = 3'b011;
      long_sel = 1'b1;
      step(4);
      supply_ok = '1;
      step(SYNC + LONG - 1);
      check("R3 long not yet", 1'b0);
      step(1);
      check("R3 long timeout", 1'b1);
      long_sel = 1'b0;
      step(4);
   endtask

   task automatic t_hold_keep_high();
      // hold and flag drop on the same edge: hold must win
      hold_req = 1'b1;
      supply_ok = 3'b001;
      step(SYNC + 1);
      check("R5 same-cycle hold wins", 1'b1);
      step(5);
      check("R5 held during bad flags", 1'b1);
      supply_ok = '1;
      step(3);
      hold_req = 1'b0;
      step(10);
      check("R6 stays released", 1'b1);
   endtask

   task automatic t_release_bad();
      hold_req = 1'b1;
      step(4);
      supply_ok = 3'b110;
      step(4);
      check("R5 bad flag ignored", 1'b1);
      hold_req = 1'b0;
      step(SYNC + DLY);
      check("R7 before release delay", 1'b1);
      step(1);
      check("R7 asserts after delay", 1'b0);
   endtask

   task automatic t_release_low();
      supply_ok = '1;
      step(3);
      hold_req = 1'b1;
      step(SYNC + 1);
      check("R8 held low", 1'b0);
      step(10);
      check("R8 held low long", 1'b0);
      hold_req = 1'b0;
      step(SYNC + SHORT);
      check("R8 partial count discarded", 1'b0);
      step(1);
      check("R8 full timeout after release", 1'b1);
      supply_ok = 3'b110;
      step(4);
      hold_req = 1'b1;
      step(4);
      hold_req = 1'b0;
      step(10);
      check("R8 bad flag keeps asserted", 1'b0);
   endtask

   task automatic t_power_hold();
      por_n = 1'b0;
      hold_req = 1'b1;
      supply_ok = '1;
      step(2);
      por_n = 1'b1;
      step(20);
      check("R9 hold at power-up", 1'b0);
      hold_req = 1'b0;
      step(SYNC + SHORT);
      check("R9 timeout starts at release", 1'b0);
      step(1);
      check("R9 released after timeout", 1'b1);
   endtask

   initial begin
      t_reset();
      t_short_timeout();
      t_drop_and_glitch();
      t_long_select();
      t_hold_keep_high();
      t_release_bad();
      t_release_low();
      t_power_hold();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: finished=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule